// File: doc/BRIEF.md
# Dual-Channel Acquisition Block Controller

This block runs one acquisition block made of two ADC channels that share a single set of settings. On every sample tick it writes the two ADC words into two per-channel sample buffers at the same address. The tick comes either from a divided internal clock or from rising edges of an external sample clock. Before the trigger the buffers run as a circular store. After the trigger arrives, the block writes a programmed number of further samples and then stops. An optional external gate can qualify each tick.

A host programs the block through a small register port with 16-bit data. After a capture it selects a channel and drains that channel's buffer through one fixed data address. Each read of that address returns the next sample, oldest first. The external clock, trigger and gate inputs are assumed to be already synchronous to `clk`.

Register addresses on `reg_addr`: 0 control (write only), 1 configuration, 2 rate divider, 3 post-trigger count, 4 prescaler, 5 channel select, 6 status (read only), 7 sample data (read only).

Top module: `acq_pair_ctrl`

## Requirements
- R1: After reset, `reg_rdata` is 0, and reading status (address 6) or any configuration register returns 0.
- R2: Writing control (address 0) with bit 0 set arms the block. Status bit 0 (armed) reads 1, done and triggered clear, and capture restarts at buffer address 0.
- R3: Configuration bit 0 selects the tick source. When it is 1, one sample is taken per rising edge of `ext_clk`. When it is 0, one sample is taken every (prescaler+1)·(rate+1) cycles, counted from the arm write.
- R4: Every stored tick writes `adc_a` into the channel 0 buffer and `adc_b` into the channel 1 buffer at the same address.
- R5: Configuration bit 1 selects the trigger source. When it is 0, the trigger is a control write with bit 1 set. When it is 1, the trigger is an edge on `ext_trig`: a rising edge when configuration bit 3 is 0, a falling edge when it is 1. The edge of the other polarity has no effect. A trigger moves status to bit 1 (triggered) with bit 0 cleared.
- R6: After the trigger, exactly as many samples as the post-trigger count are stored, and then status bit 2 (done) sets. A count of 0 gives done in the trigger cycle. A tick in the trigger cycle counts as pre-trigger.
- R7: When configuration bit 2 is 1, a tick is stored only while `ext_gate` is 1. A gated-out tick is neither stored nor counted toward the post-trigger count.
- R8: Before the trigger the write address wraps modulo the buffer depth. Status bit 3 (wrapped) sets on the first wrap and stays set until the next arm.
- R9: Writing channel select (address 5, bit 0 = channel) selects the channel to stream and moves the read pointer to the oldest stored sample. That is address 0 if the buffer has not wrapped, otherwise the current write address.
- R10: Each read of address 7 returns the sample at the read pointer in `reg_rdata` one cycle after the strobe, zero-extended. The pointer then advances modulo the buffer depth.
- R11: Once done, further ticks leave both buffers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid the cycle after `reg_rd` |
| adc_a | input | DW | Channel 0 ADC word |
| adc_b | input | DW | Channel 1 ADC word |
| ext_clk | input | 1 | External sample clock (synchronous level) |
| ext_trig | input | 1 | External trigger |
| ext_gate | input | 1 | External acquisition gate |

## Verification
A register write takes effect at the clock edge that samples it. A read strobe latches `reg_rdata` at its own edge, so a status read shows the state left by the edge before it. An external sample is stored at the first edge that sees `ext_clk` high. An external trigger is taken at the first edge that sees the new `ext_trig` level. With the internal source and prescaler 1, rate 2, the stores land six and twelve edges after the arm. The bench drives every input on the falling edge and reads `reg_rdata` on the falling edge after the strobe edge. Its status probes are placed one edge before and one edge after the expected twelfth-edge completion.

// File: rtl/acq_pkg.sv
package acq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_POST  = 2'd2,
        ST_DONE  = 2'd3
    } acq_state_e;

    // bit0 clk_ext, bit1 trig_ext, bit2 gate_en, bit3 trig_fall
    typedef struct packed {
        logic trig_fall;
        logic gate_en;
        logic trig_ext;
        logic clk_ext;
    } acq_cfg_t;

    localparam logic [2:0] RA_CTRL   = 3'd0;
    localparam logic [2:0] RA_CFG    = 3'd1;
    localparam logic [2:0] RA_RATE   = 3'd2;
    localparam logic [2:0] RA_POST   = 3'd3;
    localparam logic [2:0] RA_PRESC  = 3'd4;
    localparam logic [2:0] RA_CHSEL  = 3'd5;
    localparam logic [2:0] RA_STATUS = 3'd6;
    localparam logic [2:0] RA_DATA   = 3'd7;

    localparam int NUM_CH = 2;
endpackage

// File: rtl/acq_tick_gen.sv
module acq_tick_gen #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          use_ext,
    input  logic          ext_clk,
    input  logic [CW-1:0] presc,
    input  logic [CW-1:0] rate,
    output logic          tick
);
    typedef struct packed {
        logic [CW-1:0] base_cnt;
        logic [CW-1:0] rate_cnt;
        logic          ext_q;
    } tg_t;

    tg_t q, d;

    always_comb begin
        d       = q;
        tick    = 1'b0;
        d.ext_q = ext_clk;
        if (restart) begin
            d.base_cnt = '0;
            d.rate_cnt = '0;
        end else if (use_ext) begin
            tick = ext_clk & ~q.ext_q;
        end else if (q.base_cnt >= presc) begin
            d.base_cnt = '0;
            if (q.rate_cnt >= rate) begin
                d.rate_cnt = '0;
                tick       = 1'b1;
            end else begin
                d.rate_cnt = q.rate_cnt + 1'b1;
            end
        end else begin
            d.base_cnt = q.base_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R3
    ext_single_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (use_ext && tick) |=> !tick);
endmodule

// File: rtl/acq_seq.sv
module acq_seq
    import acq_pkg::*;
#(
    parameter int AW = 6,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic          soft_trig,
    input  acq_cfg_t      cfg,
    input  logic [CW-1:0] post_len,
    input  logic          tick,
    input  logic          ext_trig,
    input  logic          ext_gate,
    output logic          we,
    output logic [AW-1:0] waddr,
    output acq_state_e    state,
    output logic          wrapped
);
    typedef struct packed {
        acq_state_e    state;
        logic [AW-1:0] wptr;
        logic          wrapped;
        logic [CW-1:0] cnt;
        logic          trig_q;
    } seq_t;

    seq_t q, d;
    logic edge_seen, trig_evt, store, capturing, last_post;

    always_comb begin
        d         = q;
        we        = 1'b0;
        d.trig_q  = ext_trig;
        edge_seen = cfg.trig_fall ? (q.trig_q & ~ext_trig) : (~q.trig_q & ext_trig);
        trig_evt  = cfg.trig_ext ? edge_seen : soft_trig;
        store     = tick & (~cfg.gate_en | ext_gate);
        capturing = (q.state == ST_ARMED) || (q.state == ST_POST);
        last_post = ({1'b0, q.cnt} + 1'b1) >= {1'b0, post_len};
        if (arm) begin
            d.state   = ST_ARMED;
            d.wptr    = '0;
            d.wrapped = 1'b0;
            d.cnt     = '0;
        end else begin
            if (capturing && store) begin
                we     = 1'b1;
                d.wptr = q.wptr + 1'b1;
                if (q.wptr == '1) d.wrapped = 1'b1;
            end
            case (q.state)
                ST_ARMED: if (trig_evt) begin
                    d.cnt   = '0;
                    d.state = (post_len == '0) ? ST_DONE : ST_POST;
                end
                ST_POST: if (store) begin
                    d.cnt = q.cnt + 1'b1;
                    if (last_post) d.state = ST_DONE;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign waddr   = q.wptr;
    assign state   = q.state;
    assign wrapped = q.wrapped;

    // R6
    post_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_POST) |-> (q.cnt < post_len));
    // R11
    done_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_DONE && !arm) |=> ($stable(q.wptr) && q.state == ST_DONE));
    // R8
    wrap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.wrapped && !arm) |=> q.wrapped);
endmodule

// File: rtl/acq_buf.sv
module acq_buf #(
    parameter int AW = 6,
    parameter int WW = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [WW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [WW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [WW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/acq_pair_ctrl.sv
module acq_pair_ctrl
    import acq_pkg::*;
#(
    parameter int DW = 12,
    parameter int AW = 6,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [2:0]    reg_addr,
    input  logic [15:0]   reg_wdata,
    output logic [15:0]   reg_rdata,
    input  logic [DW-1:0] adc_a,
    input  logic [DW-1:0] adc_b,
    input  logic          ext_clk,
    input  logic          ext_trig,
    input  logic          ext_gate
);
    localparam int RW = 16;

    typedef struct packed {
        acq_cfg_t      cfg;
        logic [CW-1:0] rate;
        logic [CW-1:0] post;
        logic [CW-1:0] presc;
        logic          chsel;
        logic [AW-1:0] rptr;
        logic [RW-1:0] rdata;
    } top_t;

    top_t q, d;
    logic arm, soft_trig, tick, buf_we, wrapped, triggered;
    logic [AW-1:0] wptr;
    acq_state_e    state;
    logic [RW-1:0] wr_word [NUM_CH];
    logic [RW-1:0] rd_word [NUM_CH];

    assign arm       = reg_wr && (reg_addr == RA_CTRL) && reg_wdata[0];
    assign soft_trig = reg_wr && (reg_addr == RA_CTRL) && reg_wdata[1];
    assign wr_word[0] = RW'(adc_a);
    assign wr_word[1] = RW'(adc_b);
    assign triggered = (state == ST_POST) || (state == ST_DONE);

    acq_tick_gen #(.CW(CW)) u_tick (
        .clk(clk), .rst_n(rst_n), .restart(arm), .use_ext(q.cfg.clk_ext),
        .ext_clk(ext_clk), .presc(q.presc), .rate(q.rate), .tick(tick)
    );

    acq_seq #(.AW(AW), .CW(CW)) u_seq (
        .clk(clk), .rst_n(rst_n), .arm(arm), .soft_trig(soft_trig), .cfg(q.cfg),
        .post_len(q.post), .tick(tick), .ext_trig(ext_trig), .ext_gate(ext_gate),
        .we(buf_we), .waddr(wptr), .state(state), .wrapped(wrapped)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_buf
        acq_buf #(.AW(AW), .WW(RW)) u_buf (
            .clk(clk), .we(buf_we), .waddr(wptr), .wdata(wr_word[ch]),
            .raddr(q.rptr), .rdata(rd_word[ch])
        );
    end

    always_comb begin
        d = q;
        if (reg_wr) begin
            case (reg_addr)
                RA_CFG:   d.cfg   = acq_cfg_t'(reg_wdata[3:0]);
                RA_RATE:  d.rate  = reg_wdata[CW-1:0];
                RA_POST:  d.post  = reg_wdata[CW-1:0];
                RA_PRESC: d.presc = reg_wdata[CW-1:0];
                RA_CHSEL: begin
                    d.chsel = reg_wdata[0];
                    d.rptr  = wrapped ? wptr : '0;
                end
                default: ;
            endcase
        end
        if (reg_rd) begin
            case (reg_addr)
                RA_CFG:    d.rdata = RW'(q.cfg);
                RA_RATE:   d.rdata = RW'(q.rate);
                RA_POST:   d.rdata = RW'(q.post);
                RA_PRESC:  d.rdata = RW'(q.presc);
                RA_CHSEL:  d.rdata = RW'(q.chsel);
                RA_STATUS: d.rdata = RW'({wrapped, state == ST_DONE, triggered, state == ST_ARMED});
                RA_DATA: begin
                    d.rdata = rd_word[q.chsel];
                    d.rptr  = q.rptr + 1'b1;
                end
                default:   d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign reg_rdata = q.rdata;

    // R10
    rptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == RA_DATA) |=> (q.rptr == AW'($past(q.rptr) + 1'b1)));
    // R7
    gate_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_we && q.cfg.gate_en) |-> ext_gate);
    // R2
    arm_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (state == ST_ARMED && !wrapped && wptr == '0));
endmodule

// File: tb/sim_acq_pair_ctrl.sv
module sim_acq_pair_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [11:0] adc_a = '0, adc_b = '0;
    logic        ext_clk = 1'b0, ext_trig = 1'b0, ext_gate = 1'b0;
    int          checks = 0, fails = 0;
    logic [15:0] v;

    always #4 clk = ~clk;

    acq_pair_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .adc_a(adc_a), .adc_b(adc_b),
        .ext_clk(ext_clk), .ext_trig(ext_trig), .ext_gate(ext_gate)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic wr(input logic [2:0] a, input logic [15:0] dat);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = dat;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] dat);
        reg_rd = 1'b1; reg_addr = a;
        @(posedge clk); @(negedge clk);
        reg_rd = 1'b0;
        dat = reg_rdata;
    endtask

    task automatic smp(input int a, input int b, input logic g);
        adc_a = 12'(a); adc_b = 12'(b); ext_gate = g; ext_clk = 1'b1;
        @(posedge clk); @(negedge clk);
        ext_clk = 1'b0;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic trig(input logic lvl);
        ext_trig = lvl;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 rdata", reg_rdata, 16'd0);
        rd(3'd6, v); chk("R1 status", v, 16'd0);
        rd(3'd3, v); chk("R1 post", v, 16'd0);
        rd(3'd1, v); chk("R1 cfg", v, 16'd0);
    endtask

    task automatic t_wrap;
        wr(3'd1, 16'h3); wr(3'd3, 16'd2); wr(3'd0, 16'h1);
        for (int i = 0; i < 70; i++) smp(1000 + i, 2000 + i, 1'b0);
        rd(3'd6, v); chk("R8 wrapped while armed", v, 16'd9);
        trig(1'b1); trig(1'b0);
        smp(1070, 2070, 1'b0); smp(1071, 2071, 1'b0);
        rd(3'd6, v); chk("R8 wrapped done status", v, 16'd14);
        wr(3'd5, 16'd0);
        for (int i = 0; i < 64; i++) begin
            rd(3'd7, v); chk("R9 R10 wrapped stream ch0", v, 16'(1008 + i));
        end
        rd(3'd7, v); chk("R10 pointer wraps", v, 16'd1008);
        wr(3'd5, 16'd1);
        rd(3'd7, v); chk("R4 R9 oldest ch1", v, 16'd2008);
        rd(3'd7, v); chk("R4 ch1 next", v, 16'd2009);
    endtask

    task automatic t_basic;
        wr(3'd1, 16'h3); wr(3'd3, 16'd3); wr(3'd0, 16'h1);
        rd(3'd6, v); chk("R2 armed", v, 16'd1);
        for (int i = 0; i < 5; i++) smp(100 + i, 200 + i, 1'b0);
        trig(1'b1);
        rd(3'd6, v); chk("R5 rising trigger", v, 16'd2);
        smp(105, 205, 1'b0); smp(106, 206, 1'b0);
        rd(3'd6, v); chk("R6 not yet done", v, 16'd2);
        smp(107, 207, 1'b0);
        rd(3'd6, v); chk("R6 done after post count", v, 16'd6);
        trig(1'b0);
        smp(900, 900, 1'b0); smp(901, 901, 1'b0);
        wr(3'd5, 16'd0);
        for (int i = 0; i < 8; i++) begin
            rd(3'd7, v); chk("R4 ch0 data", v, 16'(100 + i));
        end
        rd(3'd7, v); chk("R11 no store after done", v, 16'd1008);
        wr(3'd5, 16'd1);
        rd(3'd7, v); chk("R4 ch1 data", v, 16'd200);
        rd(3'd7, v); rd(3'd7, v);
        wr(3'd5, 16'd1);
        rd(3'd7, v); chk("R9 select resets pointer", v, 16'd200);
        rd(3'd5, v); chk("R9 select readback", v, 16'd1);
    endtask

    task automatic t_gate;
        wr(3'd1, 16'h7); wr(3'd3, 16'd1); wr(3'd0, 16'h1);
        smp(300, 0, 1'b1); smp(301, 0, 1'b0); smp(302, 0, 1'b1);
        trig(1'b1); trig(1'b0);
        smp(303, 0, 1'b0);
        rd(3'd6, v); chk("R7 gated tick not counted", v, 16'd2);
        smp(304, 0, 1'b1);
        rd(3'd6, v); chk("R7 gated done", v, 16'd6);
        wr(3'd5, 16'd0);
        rd(3'd7, v); chk("R7 first stored", v, 16'd300);
        rd(3'd7, v); chk("R7 gated-out skipped", v, 16'd302);
        rd(3'd7, v); chk("R7 post sample", v, 16'd304);
    endtask

    task automatic t_fall;
        wr(3'd1, 16'hB); wr(3'd3, 16'd1); wr(3'd0, 16'h1);
        smp(400, 0, 1'b0);
        trig(1'b1);
        rd(3'd6, v); chk("R5 rising ignored in falling mode", v, 16'd1);
        trig(1'b0);
        rd(3'd6, v); chk("R5 falling trigger", v, 16'd2);
        smp(401, 0, 1'b0);
        rd(3'd6, v); chk("R6 falling done", v, 16'd6);
        wr(3'd5, 16'd0);
        rd(3'd7, v); chk("R5 fall data0", v, 16'd400);
        rd(3'd7, v); chk("R5 fall data1", v, 16'd401);
    endtask

    task automatic t_post0;
        wr(3'd1, 16'h3); wr(3'd3, 16'd0); wr(3'd0, 16'h1);
        smp(500, 0, 1'b0);
        trig(1'b1);
        rd(3'd6, v); chk("R6 zero post done at trigger", v, 16'd6);
        trig(1'b0);
        smp(501, 0, 1'b0);
        wr(3'd5, 16'd0);
        rd(3'd7, v); chk("R6 zero post data", v, 16'd500);
        rd(3'd7, v); chk("R11 zero post no extra", v, 16'd401);
    endtask

    task automatic t_internal;
        adc_a = 12'd77;
        wr(3'd1, 16'h0); wr(3'd4, 16'd1); wr(3'd2, 16'd2); wr(3'd3, 16'd2);
        wr(3'd0, 16'h1);
        wr(3'd0, 16'h2);
        repeat (9) @(negedge clk);
        rd(3'd6, v); chk("R3 internal not done at edge 10", v, 16'd2);
        @(negedge clk);
        rd(3'd6, v); chk("R3 internal done at edge 12", v, 16'd6);
        wr(3'd5, 16'd0);
        rd(3'd7, v); chk("R3 internal sample0", v, 16'd77);
        rd(3'd7, v); chk("R3 internal sample1", v, 16'd77);
        rd(3'd7, v); chk("R3 third slot untouched", v, 16'd304);
        rd(3'd4, v); chk("R3 prescaler readback", v, 16'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_wrap();
        t_basic();
        t_gate();
        t_fall();
        t_post0();
        t_internal();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule